// File: doc/BRIEF.md
# Indexed Register Port with Indirect PHY Management Access

This block is a small byte-wide register file for an Ethernet MAC, reached through only two host locations. The host writes a register number to the index location, and every following access to the data location reads or writes the register that number selects. The file holds the six station address bytes and the group of registers used for indirect PHY access.

PHY registers are never mapped into the host space. To reach one, software writes the PHY register number and PHY select field, loads the two data bytes for a write, and then writes the command register with a read or write request. The block raises a busy flag and shifts out a management frame on a divided clock: a preamble of ones, start, opcode, PHY address, register address, turnaround and sixteen data bits. A register-array model of the PHY sits on the serial line inside the block. It decodes the frame independently, answers reads and applies writes. When the frame ends, busy clears and any read result is in the data bytes.

Top module: `phy_mgmt_regport`

## Requirements
- R1: A host write with `bus_port`=0 latches the 8-bit index, which reads back on `bus_rdata` while `bus_port`=0. Accesses with `bus_port`=1 read or write the register that the index selects.
- R2: An index that maps to no register reads as 0x00 on the data location, and writes to it have no visible effect.
- R3: Indices 0x10 through 0x15 are six independent station address bytes, reset to 0x00, each written and read one byte at a time.
- R4: The command register is at index 0x0B and reads as {4'b0, select(bit3), read(bit2), write(bit1), busy(bit0)}. Busy is read-only, resets to 0, and reads 1 in the first cycle after a command write that starts a transaction.
- R5: A command write with bit3=1 and exactly one of bit1 (write) or bit2 (read) starts a transaction. A write transaction stores {index 0x0E, index 0x0D} (high byte, low byte) into the addressed PHY register.
- R6: When busy clears after a read transaction, index 0x0D holds the low byte and 0x0E the high byte of the addressed PHY register. Untouched model registers read 16'hA500 | register number.
- R7: The PHY address register at index 0x0C carries the PHY register number in bits 4:0 and the PHY select in bits 7:6, which form the PHY address. Value 01 reaches the internal PHY at address 1. Any other value addresses no PHY: a read returns 0xFFFF and a write changes nothing.
- R8: A command register write that arrives while busy is ignored. The register keeps its value and the running transaction completes normally.
- R9: Each transaction is exactly 64 MDC rising edges. The frame is 32 ones, start 01, opcode (01 write, 10 read), 5-bit PHY address, 5-bit register address, turnaround 10 on writes, and 16 data bits MSB first. MDIO changes only while MDC is low.
- R10: After completion, writing the command register with only bit3 set keeps the select bit readable, starts nothing, and leaves MDC idle at 0.
- R11: A command write with bit3=0 is stored but starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Host write strobe qualifier |
| bus_wr | input | 1 | Host write when high together with bus_en |
| bus_port | input | 1 | 0 selects index location, 1 selects data location |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Index (port 0) or selected register (port 1) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Resolved management data line level |

## Verification
The hardest state to reach from the ports is a second command arriving in the middle of a running frame. The bench gets there by starting a PHY read and, while busy still reads 1, writing a write command to the same register. It then confirms that the command register is unchanged and that the read result is still correct. A second hard case is an exchange that nothing answers. The bench sets the PHY select field to a value other than 01 and checks that the released line yields 0xFFFF. It also checks that a write to that address leaves the internal model's register untouched. The frame layout is checked bit by bit by recording MDIO at every MDC rising edge.

// File: rtl/phy_mgmt_regport.sv
module phy_mgmt_regport #(
  parameter int          CLK_DIV  = 2,
  parameter logic [4:0]  PHY_ADDR = 5'd1,
  parameter int          PHY_REGS = 32,
  parameter logic [7:0]  MAC_BASE = 8'h10,
  parameter int          MAC_LEN  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_wr,
  input  logic       bus_port,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       mdc_o,
  output logic       mdio_o
);
  localparam logic [7:0] IDX_CMD  = 8'h0B;
  localparam logic [7:0] IDX_PADR = 8'h0C;
  localparam logic [7:0] IDX_DLO  = 8'h0D;
  localparam logic [7:0] IDX_DHI  = 8'h0E;
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int RW = $clog2(PHY_REGS);

  logic [7:0]  idx_q, paddr_q, dlo_q, dhi_q;
  logic [7:0]  mac_q [MAC_LEN];
  logic [2:0]  cmd_q;
  logic        busy_q, is_rd_q, mdc_q;
  logic [5:0]  hidx_q;
  logic [DW-1:0] div_q;
  logic [63:0] frame_q;
  logic [15:0] rx_q;

  wire wr_idx = bus_en & bus_wr & ~bus_port;
  wire wr_dat = bus_en & bus_wr & bus_port;
  wire cmd_wr = wr_dat & (idx_q == IDX_CMD) & ~busy_q;
  wire start  = cmd_wr & bus_wdata[3] & (bus_wdata[1] ^ bus_wdata[2]);
  wire tick   = div_q == DW'(CLK_DIV - 1);
  wire mdc_rise = busy_q & tick & ~mdc_q;
  wire mdc_fall = busy_q & tick & mdc_q;
  wire done     = mdc_fall & (hidx_q == 6'd63);

  logic host_en, host_out, phy_drv, phy_out, mdio_line;
  assign host_en   = busy_q & (~is_rd_q | (hidx_q < 6'd46));
  assign host_out  = frame_q[6'd63 - hidx_q];
  assign mdio_line = host_en ? host_out : (phy_drv ? phy_out : 1'b1);
  assign mdio_o    = mdio_line;
  assign mdc_o     = mdc_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idx_q <= '0;
    else if (wr_idx) idx_q <= bus_wdata;

  for (genvar g = 0; g < MAC_LEN; g++) begin : g_mac
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mac_q[g] <= '0;
      else if (wr_dat && idx_q == MAC_BASE + 8'(g)) mac_q[g] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      paddr_q <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      cmd_q   <= '0;
    end else begin
      if (wr_dat && idx_q == IDX_PADR) paddr_q <= bus_wdata;
      if (cmd_wr) cmd_q <= bus_wdata[3:1];
      if (done && is_rd_q) begin
        dlo_q <= rx_q[7:0];
        dhi_q <= rx_q[15:8];
      end else begin
        if (wr_dat && idx_q == IDX_DLO) dlo_q <= bus_wdata;
        if (wr_dat && idx_q == IDX_DHI) dhi_q <= bus_wdata;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      mdc_q   <= 1'b0;
      hidx_q  <= '0;
      div_q   <= '0;
      frame_q <= '0;
      rx_q    <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      is_rd_q <= bus_wdata[2];
      mdc_q   <= 1'b0;
      hidx_q  <= '0;
      div_q   <= '0;
      frame_q <= {32'hFFFF_FFFF, 2'b01, bus_wdata[2] ? 2'b10 : 2'b01,
                  3'b000, paddr_q[7:6], paddr_q[4:0], 2'b10, dhi_q, dlo_q};
    end else if (busy_q) begin
      if (tick) begin
        div_q <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          if (is_rd_q && hidx_q >= 6'd48) rx_q <= {rx_q[14:0], mdio_line};
        end else if (hidx_q == 6'd63) busy_q <= 1'b0;
        else hidx_q <= hidx_q + 6'd1;
      end else div_q <= div_q + DW'(1);
    end

  always_comb begin
    bus_rdata = 8'h00;
    if (!bus_port) bus_rdata = idx_q;
    else begin
      case (idx_q)
        IDX_CMD:  bus_rdata = {4'b0, cmd_q, busy_q};
        IDX_PADR: bus_rdata = paddr_q;
        IDX_DLO:  bus_rdata = dlo_q;
        IDX_DHI:  bus_rdata = dhi_q;
        default: ;
      endcase
      for (int i = 0; i < MAC_LEN; i++)
        if (idx_q == MAC_BASE + 8'(i)) bus_rdata = mac_q[i];
    end
  end

  logic [15:0] preg [PHY_REGS];
  logic [6:0]  m_pos;
  logic [5:0]  m_ones;
  logic [15:0] m_sh;
  logic        m_rd, m_wr, m_hit;
  logic [RW-1:0] m_reg;
  wire  [12:0] m_hdr = {m_sh[11:0], mdio_line};
  wire  [3:0]  m_bit = 4'(7'd63 - m_pos);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < PHY_REGS; i++) preg[i] <= 16'hA500 | 16'(i);
      m_pos   <= '0;
      m_ones  <= '0;
      m_sh    <= '0;
      m_rd    <= 1'b0;
      m_wr    <= 1'b0;
      m_hit   <= 1'b0;
      m_reg   <= '0;
      phy_drv <= 1'b0;
      phy_out <= 1'b1;
    end else if (mdc_rise) begin
      m_sh <= {m_sh[14:0], mdio_line};
      if (m_pos == 7'd0) begin
        if (mdio_line) m_ones <= (m_ones == 6'd32) ? 6'd32 : m_ones + 6'd1;
        else begin
          if (m_ones == 6'd32) m_pos <= 7'd33;
          m_ones <= '0;
        end
      end else begin
        m_pos <= m_pos + 7'd1;
        if (m_pos == 7'd45) begin
          m_rd  <= m_hdr[11:10] == 2'b10;
          m_wr  <= m_hdr[11:10] == 2'b01;
          m_hit <= m_hdr[9:5] == PHY_ADDR;
          m_reg <= m_hdr[RW-1:0];
        end
        if (m_pos == 7'd63) begin
          m_pos <= '0;
          if (m_wr && m_hit) preg[m_reg] <= {m_sh[14:0], mdio_line};
        end
      end
    end else if (mdc_fall) begin
      if (m_rd && m_hit && m_pos >= 7'd47) begin
        phy_drv <= 1'b1;
        phy_out <= (m_pos == 7'd47) ? 1'b0 : preg[m_reg][m_bit];
      end else phy_drv <= 1'b0;
    end

  assert_frame_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(hidx_q) == 6'd63);
  assert_busy_from_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wr_dat && idx_q == IDX_CMD && bus_wdata[3]));
  assert_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_dat && idx_q == IDX_CMD) |=> $stable(cmd_q));
  assert_one_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_en && phy_drv));
  assert_mdc_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc_q);
  assert_mdio_low_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_q && $past(mdc_q) |-> $stable(mdio_line));
endmodule

// File: tb/phy_mgmt_regport_tb.sv
module phy_mgmt_regport_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_wr = 0, bus_port = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic mdc, mdio;
  int checks = 0, errors = 0;
  logic [63:0] mon_bits;
  int mon_n = 0;

  always #5 clk = ~clk;

  phy_mgmt_regport dut_i (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc_o(mdc), .mdio_o(mdio));

  always @(posedge mdc) begin
    if (mon_n < 64) mon_bits[63 - mon_n] = mdio;
    mon_n++;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic port, logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_port = port; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic host_rd(logic port, output logic [7:0] d);
    @(negedge clk);
    bus_port = port;
    #1 d = bus_rdata;
  endtask

  task automatic reg_wr(logic [7:0] i, logic [7:0] d);
    host_wr(0, i); host_wr(1, d);
  endtask

  task automatic reg_rd(logic [7:0] i, output logic [7:0] d);
    host_wr(0, i); host_rd(1, d);
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    host_wr(0, 8'h0B);
    for (int n = 0; n < 5000; n++) begin
      host_rd(1, c);
      if (!c[0]) return;
    end
    check("R4 busy timeout", 1, 0);
  endtask

  task automatic phy_write(logic [7:0] pa, logic [15:0] v);
    reg_wr(8'h0C, pa); reg_wr(8'h0D, v[7:0]); reg_wr(8'h0E, v[15:8]);
    mon_n = 0;
    reg_wr(8'h0B, 8'h0A);
    wait_idle();
    reg_wr(8'h0B, 8'h08);
  endtask

  task automatic phy_read(logic [7:0] pa, output logic [15:0] v);
    logic [7:0] lo, hi;
    reg_wr(8'h0C, pa); reg_wr(8'h0D, 8'h00); reg_wr(8'h0E, 8'h00);
    reg_wr(8'h0B, 8'h0C);
    wait_idle();
    reg_wr(8'h0B, 8'h08);
    reg_rd(8'h0D, lo); reg_rd(8'h0E, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset();
    logic [7:0] d;
    host_rd(0, d); check("R1 reset index", d, 8'h00);
    reg_rd(8'h0B, d); check("R4 reset command", d, 8'h00);
    reg_rd(8'h10, d); check("R3 reset mac", d, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] d;
    reg_wr(8'h12, 8'hAB);
    host_rd(0, d); check("R1 index readback", d, 8'h12);
    host_rd(1, d); check("R1 data readback", d, 8'hAB);
  endtask

  task automatic t_mac();
    logic [7:0] d;
    for (int i = 0; i < 6; i++) reg_wr(8'h10 + 8'(i), 8'hC0 + 8'(i * 3));
    for (int i = 0; i < 6; i++) begin
      reg_rd(8'h10 + 8'(i), d); check("R3 mac byte", d, 8'hC0 + 8'(i * 3));
    end
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    reg_wr(8'h40, 8'h77);
    reg_rd(8'h40, d); check("R2 unmapped reads zero", d, 8'h00);
    reg_rd(8'h16, d); check("R2 past mac range", d, 8'h00);
  endtask

  task automatic t_write_frame();
    logic [7:0] d;
    logic [15:0] v;
    reg_wr(8'h0C, 8'h44); reg_wr(8'h0D, 8'h34); reg_wr(8'h0E, 8'h12);
    mon_n = 0;
    reg_wr(8'h0B, 8'h0A);
    host_rd(1, d); check("R4 busy right after start", d, 8'h0B);
    wait_idle();
    check("R9 edge count", mon_n, 64);
    check("R9 frame bits", mon_bits,
          {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, 5'd4, 2'b10, 16'h1234});
    reg_wr(8'h0B, 8'h08);
    reg_rd(8'h0B, d); check("R10 select kept", d, 8'h08);
    repeat (40) @(negedge clk);
    check("R10 no new frame", mon_n, 64);
    check("R10 mdc idle", mdc, 0);
    phy_read(8'h44, v); check("R5 write reached phy", v, 16'h1234);
  endtask

  task automatic t_read();
    logic [15:0] v;
    phy_read(8'h47, v); check("R6 read reset value", v, 16'hA507);
    phy_read(8'h5F, v); check("R6 read last register", v, 16'hA51F);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d, lo, hi;
    reg_wr(8'h0C, 8'h47);
    reg_wr(8'h0B, 8'h0C);
    repeat (20) @(negedge clk);
    host_wr(1, 8'h0A);
    host_rd(1, d); check("R8 command unchanged while busy", d, 8'h0D);
    wait_idle();
    reg_rd(8'h0B, d); check("R8 command after finish", d, 8'h0C);
    reg_rd(8'h0D, lo); reg_rd(8'h0E, hi);
    check("R8 read result intact", {hi, lo}, 16'hA507);
    reg_wr(8'h0B, 8'h08);
  endtask

  task automatic t_other_phy();
    logic [15:0] v;
    phy_read(8'h84, v); check("R7 absent phy reads ones", v, 16'hFFFF);
    phy_write(8'h85, 16'hBEEF);
    phy_read(8'h45, v); check("R7 absent phy write no effect", v, 16'hA505);
  endtask

  task automatic t_no_select();
    logic [7:0] d;
    mon_n = 0;
    reg_wr(8'h0B, 8'h02);
    host_rd(1, d); check("R11 stored without start", d, 8'h02);
    repeat (30) @(negedge clk);
    check("R11 no frame", mon_n, 0);
    reg_wr(8'h0B, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_index();
    t_mac();
    t_unmapped();
    t_write_frame();
    t_read();
    t_busy_ignore();
    t_other_phy();
    t_no_select();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule